// File: doc/BRIEF.md
# Configuration Space Access Bridge

This block sits on a host I/O request bus and turns the two-port indirect configuration scheme into direct accesses on a configuration-space target interface. Software first stores a 32-bit selector word at the selector port (0xCF8). It then reads or writes bytes, words or dwords through a four-byte window at ports 0xCFC to 0xCFF. The bridge splits the stored selector into a device/function index and a register offset, and forwards the window access to the target addressed by that index.

The bridge also guards the target. It drops writes aimed at the read-only header bytes. It answers with all-ones when the selector is not enabled for bus 0, when the addressed target is absent, and when an access length is not permitted on the port used. Host requests last one cycle. Target signals are combinational in that same cycle. Read data appears on the following clock edge and stays put until the next read.

Top module: `cfg_access_bridge`

## Requirements
- R1: A write of length 4 to port 0xCF8 stores all 32 bits of host_wdata in the selector. A read of length 4 from that port returns the stored selector unchanged.
- R2: A length-1 or length-2 access to port 0xCF8 leaves the selector unchanged. If it is a read, it returns 0xFF (length 1) or 0xFFFF (length 2).
- R3: A window access reaches the target (tgt_req high) only when selector bit 31 is 1 and selector bits 23:16 are all zero. Otherwise a window read returns 0xFFFFFFFF and a window write is dropped.
- R4: tgt_devfn equals selector bits 15:8. tgt_reg equals selector bits 7:2 with two zero bits appended, plus host_addr bits 1:0 of the window port used.
- R5: A forwarded read whose target reports tgt_present low returns 0xFFFFFFFF. A forwarded read whose target reports tgt_present high returns tgt_rdata.
- R6: A window write whose register offset is 0-3, 8-11 or 14 does not raise tgt_req. A write to offsets 4-7, 12, 13 or 15 and above is forwarded.
- R7: The window accepts lengths 1, 2 and 4 only. Any other length code, and any access to an address outside the two ports, is not forwarded. Its read value depends on the length code: 0xFF for 1, 0xFFFF for 2, and 0xFFFFFFFF for anything else.
- R8: While rst is high at a clock edge, the selector and host_rdata are cleared to zero.
- R9: host_rdata takes its new value at the clock edge that ends a read request. It holds that value through idle cycles and through write requests.
- R10: tgt_req is asserted combinationally in the same cycle as host_req. tgt_we, tgt_len and tgt_wdata carry host_we, host_len and host_wdata unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | One-cycle I/O request strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | I/O port address |
| host_len | input | 3 | Access length in bytes (1, 2 or 4) |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Registered read data |
| tgt_req | output | 1 | Forwarded access strobe |
| tgt_we | output | 1 | Forwarded write flag |
| tgt_devfn | output | 8 | Device/function index |
| tgt_reg | output | 8 | Register byte offset |
| tgt_len | output | 3 | Forwarded access length |
| tgt_wdata | output | 32 | Forwarded write data |
| tgt_present | input | 1 | Target at tgt_devfn exists |
| tgt_rdata | input | 32 | Target read data (same cycle) |

## Verification
Window reads are driven through every lane at byte, word and dword width. The target returns its own index and offset, so a wrong devfn or offset calculation shows up in the data. Writes sweep offsets on both sides of each read-only boundary (3/4, 11/12, 13/14/15) to separate the filter from the lane arithmetic. Selectors with bit 31 clear, with a nonzero bus field, and with an absent device each exercise a different path to all-ones. Narrow and illegal lengths on both ports, plus an unmapped address, show the per-length all-ones value and that the selector survives these accesses.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 3;

  // all-ones response sized by the access length code
  function automatic logic [DATA_W-1:0] ones_for_len(input logic [LEN_W-1:0] len);
    case (len)
      3'd1:    ones_for_len = 32'h0000_00FF;
      3'd2:    ones_for_len = 32'h0000_FFFF;
      default: ones_for_len = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/cfgb_port_decode.sv
module cfgb_port_decode #(
  parameter int              PORT_W      = 16,
  parameter logic [PORT_W-1:0] SEL_PORT  = 16'h0CF8,
  parameter logic [PORT_W-1:0] WIN_BASE  = 16'h0CFC
) (
  input  logic [PORT_W-1:0]         addr,
  input  logic [cfgb_pkg::LEN_W-1:0] len,
  output logic                      sel_hit,
  output logic                      sel_len_ok,
  output logic                      win_hit,
  output logic                      win_len_ok,
  output logic [1:0]                lane
);
  assign sel_hit    = (addr == SEL_PORT);
  assign sel_len_ok = (len == 3'd4);
  assign win_hit    = (addr[PORT_W-1:2] == WIN_BASE[PORT_W-1:2]);
  assign win_len_ok = (len == 3'd1) || (len == 3'd2) || (len == 3'd4);
  assign lane       = addr[1:0];
endmodule

// File: rtl/cfgb_sel_latch.sv
module cfgb_sel_latch #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] sel_q
);
  always_ff @(posedge clk) begin
    if (rst)        sel_q <= '0;
    else if (wr_en) sel_q <= wdata;
  end

  // R8
  sel_rst_chk: assert property (@(posedge clk) rst |=> sel_q == '0);
endmodule

// File: rtl/cfgb_wr_filter.sv
module cfgb_wr_filter #(
  parameter logic [15:0] RO_MASK = 16'h4F0F
) (
  input  logic [7:0] offset,
  output logic       writable
);
  logic in_header;
  assign in_header = (offset[7:4] == 4'd0);
  assign writable  = !(in_header && RO_MASK[offset[3:0]]);
endmodule

// File: rtl/cfg_access_bridge.sv
module cfg_access_bridge #(
  parameter int                PORT_W   = 16,
  parameter logic [PORT_W-1:0] SEL_PORT = 16'h0CF8,
  parameter logic [PORT_W-1:0] WIN_BASE = 16'h0CFC,
  parameter logic [15:0]       RO_MASK  = 16'h4F0F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [PORT_W-1:0] host_addr,
  input  logic [2:0]        host_len,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              tgt_req,
  output logic              tgt_we,
  output logic [7:0]        tgt_devfn,
  output logic [7:0]        tgt_reg,
  output logic [2:0]        tgt_len,
  output logic [31:0]       tgt_wdata,
  input  logic              tgt_present,
  input  logic [31:0]       tgt_rdata
);
  import cfgb_pkg::*;

  logic             sel_hit, sel_len_ok, win_hit, win_len_ok;
  logic [1:0]       lane;
  logic [DATA_W-1:0] sel_q;
  logic             enabled, writable, win_go;
  logic [DATA_W-1:0] rd_next;

  cfgb_port_decode #(.PORT_W(PORT_W), .SEL_PORT(SEL_PORT), .WIN_BASE(WIN_BASE)) dec_i (
    .addr(host_addr), .len(host_len), .sel_hit(sel_hit), .sel_len_ok(sel_len_ok),
    .win_hit(win_hit), .win_len_ok(win_len_ok), .lane(lane)
  );

  cfgb_sel_latch #(.W(DATA_W)) sel_i (
    .clk(clk), .rst(rst),
    .wr_en(host_req && host_we && sel_hit && sel_len_ok),
    .wdata(host_wdata), .sel_q(sel_q)
  );

  assign enabled   = sel_q[31] && (sel_q[23:16] == 8'd0);
  assign tgt_devfn = sel_q[15:8];
  assign tgt_reg   = {sel_q[7:2], 2'b00} + {6'd0, lane};

  cfgb_wr_filter #(.RO_MASK(RO_MASK)) flt_i (.offset(tgt_reg), .writable(writable));

  assign win_go    = host_req && win_hit && win_len_ok && enabled;
  assign tgt_req   = win_go && (!host_we || writable);
  assign tgt_we    = host_we;
  assign tgt_len   = host_len;
  assign tgt_wdata = host_wdata;

  always_comb begin
    if (sel_hit)
      rd_next = sel_len_ok ? sel_q : ones_for_len(host_len);
    else if (win_hit && !win_len_ok)
      rd_next = ones_for_len(host_len);
    else if (win_hit)
      rd_next = (enabled && tgt_present) ? tgt_rdata : '1;
    else
      rd_next = ones_for_len(host_len);
  end

  always_ff @(posedge clk) begin
    if (rst)                       host_rdata <= '0;
    else if (host_req && !host_we) host_rdata <= rd_next;
  end

  // R2
  sel_narrow_chk: assert property (@(posedge clk) disable iff (rst)
    (host_req && (host_addr == SEL_PORT) && (host_len != 3'd4)) |=> $stable(sel_q));
  // R3
  enable_gate_chk: assert property (@(posedge clk) disable iff (rst)
    tgt_req |-> (sel_q[31] && sel_q[23:16] == 8'd0));
  // R6
  ro_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (tgt_req && tgt_we) |-> !(tgt_reg inside {8'd0, 8'd1, 8'd2, 8'd3, 8'd8, 8'd9, 8'd10, 8'd11, 8'd14}));
  // R5
  absent_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (tgt_req && !tgt_we && !tgt_present) |=> host_rdata == 32'hFFFF_FFFF);
  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(host_req && !host_we) |=> $stable(host_rdata));
endmodule

// File: tb/cfg_access_bridge_tb_top.sv
module cfg_access_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0, host_we = 1'b0;
  logic [15:0] host_addr = '0;
  logic [2:0]  host_len = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        tgt_req, tgt_we, tgt_present;
  logic [7:0]  tgt_devfn, tgt_reg;
  logic [2:0]  tgt_len;
  logic [31:0] tgt_wdata, tgt_rdata;

  int   n_tests = 0, n_fail = 0;
  bit   done = 0;
  logic [31:0] sel_m = '0;
  logic [31:0] exp_rd = '0;

  always #10 clk = ~clk;

  cfg_access_bridge dut_i (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_len(host_len), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tgt_req(tgt_req), .tgt_we(tgt_we), .tgt_devfn(tgt_devfn), .tgt_reg(tgt_reg),
    .tgt_len(tgt_len), .tgt_wdata(tgt_wdata), .tgt_present(tgt_present), .tgt_rdata(tgt_rdata)
  );

  // target model: devfn 0x18..0x1F absent, data echoes index and offset
  assign tgt_present = (tgt_devfn[7:3] != 5'd3);
  assign tgt_rdata   = {tgt_devfn, tgt_reg, 16'hC0DE};

  function automatic logic [31:0] ones_m(input int len);
    if (len == 1) return 32'hFF;
    if (len == 2) return 32'hFFFF;
    return 32'hFFFF_FFFF;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference comparison of read data on every clock (R9, R8)
  always @(negedge clk) if (!done) check("R9", host_rdata, exp_rd);

  task automatic do_io(input bit we, input int addr, input int len, input logic [31:0] wd, input string req);
    bit  is_sel, is_win, len_ok, en, fwd;
    int  off;
    logic [7:0] dfn;
    logic [31:0] rv;
    is_sel = (addr == 'hCF8);
    is_win = (addr >= 'hCFC && addr <= 'hCFF);
    len_ok = (len == 1 || len == 2 || len == 4);
    en     = sel_m[31] && (sel_m[23:16] == 0);
    dfn    = sel_m[15:8];
    off    = (sel_m[7:0] & 8'hFC) + (addr & 3);
    fwd    = is_win && len_ok && en &&
             (!we || !(off <= 3 || (off >= 8 && off <= 11) || off == 14));
    host_req = 1; host_we = we; host_addr = addr[15:0]; host_len = len[2:0]; host_wdata = wd;
    #1;
    check(req, {31'd0, tgt_req}, {31'd0, fwd});
    if (fwd) begin
      check("R4", {tgt_devfn, tgt_reg}, {dfn, off[7:0]});
      check("R10", {tgt_we, tgt_len, tgt_wdata}, {we, len[2:0], wd});
    end
    if (is_sel) rv = (len == 4) ? sel_m : ones_m(len);
    else if (is_win && !len_ok) rv = ones_m(len);
    else if (is_win) rv = (en && dfn[7:3] != 5'd3) ? {dfn, off[7:0], 16'hC0DE} : 32'hFFFF_FFFF;
    else rv = ones_m(len);
    @(posedge clk);
    if (!we) exp_rd = rv;
    if (we && is_sel && len == 4) sel_m = wd;
    @(negedge clk);
    host_req = 0; host_we = 0;
    #1;
    if (!we) check(req, host_rdata, rv);
  endtask

  task automatic do_reset();
    rst = 1;
    @(posedge clk);
    sel_m = '0; exp_rd = '0;
    @(negedge clk);
    rst = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R8: reset state
    check("R8", host_rdata, 32'h0);
    do_io(0, 'hCF8, 4, 0, "R8");
    // R1
    do_io(1, 'hCF8, 4, 32'h8000_2A08, "R1");
    do_io(0, 'hCF8, 4, 0, "R1");
    // R2
    do_io(1, 'hCF8, 1, 32'hFF, "R2");
    do_io(1, 'hCF8, 2, 32'hFFFF, "R2");
    do_io(0, 'hCF8, 1, 0, "R2");
    do_io(0, 'hCF8, 2, 0, "R2");
    do_io(0, 'hCF8, 4, 0, "R2");
    // R4/R5 reads through each lane and width
    for (int a = 'hCFC; a <= 'hCFF; a++) do_io(0, a, 1, 0, "R4");
    do_io(0, 'hCFE, 2, 0, "R4");
    do_io(0, 'hCFC, 4, 0, "R5");
    // R6 write filter around boundaries
    for (int r = 0; r < 16; r += 4) begin
      do_io(1, 'hCF8, 4, 32'h8000_1100 | r, "R6");
      for (int a = 'hCFC; a <= 'hCFF; a++) do_io(1, a, 1, 32'hA5A5_0000 | a, "R6");
    end
    do_io(1, 'hCF8, 4, 32'h8000_1140, "R6");
    do_io(1, 'hCFD, 2, 32'h1234, "R6");
    do_io(0, 'hCFC, 4, 0, "R9");
    do_io(1, 'hCFC, 4, 32'h5555_AAAA, "R9");
    // R3 disabled and nonzero bus
    do_io(1, 'hCF8, 4, 32'h0000_2A10, "R3");
    do_io(0, 'hCFC, 4, 0, "R3");
    do_io(1, 'hCFC, 4, 32'h1, "R3");
    do_io(1, 'hCF8, 4, 32'h8001_2A10, "R3");
    do_io(0, 'hCFD, 1, 0, "R3");
    do_io(1, 'hCFC, 4, 32'h2, "R3");
    // R5 absent device
    do_io(1, 'hCF8, 4, 32'h8000_1A04, "R5");
    do_io(0, 'hCFC, 4, 0, "R5");
    do_io(0, 'hCFE, 1, 0, "R5");
    // R7 illegal lengths and unmapped ports
    do_io(1, 'hCF8, 4, 32'h8000_0810, "R7");
    do_io(0, 'hCFC, 3, 0, "R7");
    do_io(1, 'hCFC, 0, 32'h9, "R7");
    do_io(0, 'hCFD, 7, 0, "R7");
    do_io(0, 'h0080, 1, 0, "R7");
    do_io(0, 'h0080, 2, 0, "R7");
    do_io(0, 'hCF9, 4, 0, "R7");
    do_io(1, 'hCF9, 4, 32'h0, "R7");
    do_io(0, 'hCF8, 4, 0, "R7");
    // R8 mid-run reset
    do_reset();
    check("R8", host_rdata, 32'h0);
    do_io(0, 'hCF8, 4, 0, "R8");
    do_io(0, 'hCFC, 4, 0, "R8");
    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    done = 1;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule